// File: doc/BRIEF.md
# Effective Address and Next-PC Unit

This combinational unit sits beside the instruction register of a 16-bit, word-addressed processor. From the current instruction word, the already incremented program counter, one base-register value, the three result flags and a word returned from the trap vector table, it produces four things:

- the address for the memory address register;
- the program counter for the next instruction;
- a flag that shows a conditional branch was taken;
- a link write of the return address into register 7.

Offsets come in three signed widths: 9, 11 and 6 bits. The opcode picks the width. The unit performs no memory access and holds no register file. The base register named by the instruction is read outside the unit and arrives on `base_val`.

The unit sees a trap as one instruction. The address output carries the table index. The next-PC output forwards whatever word the table read returns on `vec_data`. A control sequencer around the unit takes these values at the right steps.

Top module: `addr_pc_gen`

## Requirements
- R1: For opcodes 0010, 0011, 1010, 1011 and 1110 (and for 0000), `mar_addr` equals `pc_inc` plus bits 8:0 sign-extended, modulo 2^16.
- R2: For opcodes 0110 and 0111, `mar_addr` equals `base_val` plus bits 5:0 sign-extended, so the offset spans −32 to +31.
- R3: Opcode 0000 is a conditional branch. Bit 11 masks N, bit 10 masks Z and bit 9 masks P. `br_taken` is 1 exactly when a masked flag is set. `next_pc` is then the R1 address, and otherwise it is `pc_inc`.
- R4: A branch whose three mask bits are all zero is never taken, and `next_pc` stays `pc_inc`.
- R5: Opcode 1100 sets `next_pc` to `base_val` and performs no link write.
- R6: Opcode 0100 with bit 11 = 1 sets `next_pc` to `pc_inc` plus bits 10:0 sign-extended. With bit 11 = 0 it sets `next_pc` to `base_val`. Both forms assert `link_we` with `link_data` = `pc_inc`.
- R7: Opcode 1111 sets `mar_addr` to bits 7:0 zero-extended and `next_pc` to `vec_data`. It also asserts `link_we` with `link_data` = `pc_inc`.
- R8: For opcodes 0001, 0101, 1000, 1001 and 1101, `next_pc` is `pc_inc`, `br_taken` is 0 and `link_we` is 0.
- R9: `link_we` is 1 only for opcodes 0100 and 1111. `br_taken` is 1 only for opcode 0000. `link_data` is zero whenever `link_we` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr | input | 16 | Current instruction word |
| pc_inc | input | 16 | Program counter already incremented past this instruction |
| base_val | input | 16 | Value of the base register named by bits 8:6 |
| flag_n | input | 1 | Last result was negative |
| flag_z | input | 1 | Last result was zero |
| flag_p | input | 1 | Last result was positive |
| vec_data | input | 16 | Word read from the trap vector table |
| mar_addr | output | 16 | Address toward the memory address register |
| next_pc | output | 16 | Selected next program counter |
| br_taken | output | 1 | Conditional branch taken |
| link_we | output | 1 | Write return address to register 7 |
| link_data | output | 16 | Return address value |

## Verification
Random instruction words are drawn across all sixteen opcodes, together with random PC, base and flag values.

- Random PC and base values catch a wrong adder input.
- Random offsets with either sign catch a sign extension taken from the wrong bit.
- Directed words push each offset field to its extreme negative and positive values at a PC near 0 or 0xFFFF, so a wrong width or a missing wraparound shows up in the sum.
- Each branch mask is tried against each single set flag, and the all-zero mask against all flags set. Together these separate any-of from all-of evaluation and confirm the never-taken case.
- The trap cases use vector 0xFF with a table word unlike every other input, which exposes sign extension of the vector and any wrong next-PC source.

// File: rtl/addr_pc_pkg.sv
package addr_pc_pkg;
  parameter int unsigned XLEN = 16;
  localparam int unsigned OP_W = 4;
  localparam int unsigned VEC_W = 8;
  localparam int unsigned N_OFF = 3;
  // index 0: PC-relative short, 1: PC-relative long, 2: base-relative
  localparam int unsigned OFF_W [N_OFF] = '{9, 11, 6};

  typedef enum logic [OP_W-1:0] {
    OP_BR   = 4'b0000, OP_ADD  = 4'b0001, OP_LD   = 4'b0010, OP_ST   = 4'b0011,
    OP_JSR  = 4'b0100, OP_AND  = 4'b0101, OP_LDR  = 4'b0110, OP_STR  = 4'b0111,
    OP_RTI  = 4'b1000, OP_NOT  = 4'b1001, OP_LDI  = 4'b1010, OP_STI  = 4'b1011,
    OP_JMP  = 4'b1100, OP_RSV  = 4'b1101, OP_LEA  = 4'b1110, OP_TRAP = 4'b1111
  } opcode_e;

  typedef enum logic [1:0] {PCS_SEQ, PCS_CALC, PCS_BUS} pc_sel_e;
  typedef enum logic [1:0] {AS_PC_S, AS_PC_L, AS_BASE_OFF, AS_BASE_ZERO} addr_src_e;

  function automatic logic [XLEN-1:0] zext_vec(input logic [VEC_W-1:0] v);
    return {{(XLEN-VEC_W){1'b0}}, v};
  endfunction

  function automatic logic any_masked(input logic [2:0] mask, input logic [2:0] flags);
    return |(mask & flags);
  endfunction
endpackage

// File: rtl/apg_offset_adder.sv
module apg_offset_adder #(
  parameter int unsigned XLEN  = 16,
  parameter int unsigned OFF_W = 9
) (
  input  logic [XLEN-1:0]  base,
  input  logic [OFF_W-1:0] off,
  output logic [XLEN-1:0]  sum
);
  localparam int unsigned EXT_W = XLEN - OFF_W;
  logic [XLEN-1:0] off_ext;
  assign off_ext = {{EXT_W{off[OFF_W-1]}}, off};
  assign sum = base + off_ext;
endmodule

// File: rtl/apg_cond_eval.sv
module apg_cond_eval
  import addr_pc_pkg::*;
(
  input  logic       is_branch,
  input  logic [2:0] mask,
  input  logic [2:0] flags,
  output logic       taken
);
  assign taken = is_branch && any_masked(mask, flags);
endmodule

// File: rtl/apg_pc_mux.sv
module apg_pc_mux
  import addr_pc_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  pc_sel_e      sel,
  input  logic [W-1:0] seq_pc,
  input  logic [W-1:0] calc_pc,
  input  logic [W-1:0] bus_pc,
  output logic [W-1:0] next_pc
);
  always_comb begin
    unique case (sel)
      PCS_CALC: next_pc = calc_pc;
      PCS_BUS:  next_pc = bus_pc;
      default:  next_pc = seq_pc;
    endcase
  end
endmodule

// File: rtl/addr_pc_gen.sv
module addr_pc_gen
  import addr_pc_pkg::*;
(
  input  logic [15:0] instr,
  input  logic [15:0] pc_inc,
  input  logic [15:0] base_val,
  input  logic        flag_n,
  input  logic        flag_z,
  input  logic        flag_p,
  input  logic [15:0] vec_data,
  output logic [15:0] mar_addr,
  output logic [15:0] next_pc,
  output logic        br_taken,
  output logic        link_we,
  output logic [15:0] link_data
);
  opcode_e         op;
  addr_src_e       addr_src;
  pc_sel_e         pc_sel;
  logic            use_vec;
  logic            is_branch;
  logic            cond_hit;
  logic            redirect;
  logic [XLEN-1:0] off_sum [N_OFF];
  logic [XLEN-1:0] addr_calc;

  assign op = opcode_e'(instr[15:12]);

  for (genvar i = 0; i < N_OFF; i++) begin : g_off
    localparam int unsigned W = OFF_W[i];
    apg_offset_adder #(.XLEN(XLEN), .OFF_W(W)) u_add (
      .base ((i == 2) ? base_val : pc_inc),
      .off  (instr[W-1:0]),
      .sum  (off_sum[i])
    );
  end

  assign is_branch = (op == OP_BR);

  apg_cond_eval u_cond (
    .is_branch (is_branch),
    .mask      (instr[11:9]),
    .flags     ({flag_n, flag_z, flag_p}),
    .taken     (cond_hit)
  );

  always_comb begin
    addr_src = AS_PC_S;
    pc_sel   = PCS_SEQ;
    use_vec  = 1'b0;
    link_we  = 1'b0;
    unique case (op)
      OP_BR:   pc_sel = cond_hit ? PCS_CALC : PCS_SEQ;
      OP_LDR, OP_STR: addr_src = AS_BASE_OFF;
      OP_JMP: begin
        addr_src = AS_BASE_ZERO;
        pc_sel   = PCS_CALC;
      end
      OP_JSR: begin
        addr_src = instr[11] ? AS_PC_L : AS_BASE_ZERO;
        pc_sel   = PCS_CALC;
        link_we  = 1'b1;
      end
      OP_TRAP: begin
        use_vec = 1'b1;
        pc_sel  = PCS_BUS;
        link_we = 1'b1;
      end
      default: ;
    endcase
  end

  always_comb begin
    unique case (addr_src)
      AS_PC_L:      addr_calc = off_sum[1];
      AS_BASE_OFF:  addr_calc = off_sum[2];
      AS_BASE_ZERO: addr_calc = base_val;
      default:      addr_calc = off_sum[0];
    endcase
  end

  assign mar_addr  = use_vec ? zext_vec(instr[VEC_W-1:0]) : addr_calc;
  assign redirect  = (pc_sel != PCS_SEQ);
  assign br_taken  = cond_hit;
  assign link_data = link_we ? pc_inc : '0;

  apg_pc_mux #(.W(XLEN)) u_pcmux (
    .sel     (pc_sel),
    .seq_pc  (pc_inc),
    .calc_pc (addr_calc),
    .bus_pc  (vec_data),
    .next_pc (next_pc)
  );
endmodule

// File: rtl/addr_pc_gen_chk.sv
module addr_pc_gen_chk (
  input logic [15:0] instr,
  input logic [15:0] pc_inc,
  input logic [15:0] base_val,
  input logic [15:0] vec_data,
  input logic [15:0] mar_addr,
  input logic [15:0] next_pc,
  input logic [15:0] link_data,
  input logic        br_taken,
  input logic        link_we,
  input logic        redirect
);
  logic [3:0] opc;
  assign opc = instr[15:12];

  always_comb begin
    if (br_taken) begin
      assert_taken_only_br_R9: assert (opc == 4'b0000) else $error("taken on non-branch");
      assert_taken_target_R3: assert (next_pc == mar_addr) else $error("taken target mismatch");
    end
    if (opc == 4'b0000 && instr[11:9] == 3'b000) begin
      assert_zero_mask_R4: assert (!br_taken && next_pc == pc_inc) else $error("empty mask taken");
    end
    if (link_we) begin
      assert_link_value_R6: assert (link_data == pc_inc) else $error("link value");
      assert_link_ops_R9: assert (opc == 4'b0100 || opc == 4'b1111) else $error("stray link");
    end
    if (opc == 4'b1111) begin
      assert_trap_fields_R7: assert (mar_addr[15:8] == 8'h00 && next_pc == vec_data && link_we)
        else $error("trap outputs");
    end
    if (opc == 4'b1100) begin
      assert_jump_R5: assert (next_pc == base_val && !link_we) else $error("jump outputs");
    end
    if (!redirect) begin
      assert_seq_pc_R8: assert (next_pc == pc_inc) else $error("sequential pc");
    end
  end
endmodule

bind addr_pc_gen addr_pc_gen_chk u_chk (
  .instr     (instr),
  .pc_inc    (pc_inc),
  .base_val  (base_val),
  .vec_data  (vec_data),
  .mar_addr  (mar_addr),
  .next_pc   (next_pc),
  .link_data (link_data),
  .br_taken  (br_taken),
  .link_we   (link_we),
  .redirect  (redirect)
);

// File: tb/addr_pc_gen_tb.sv
module addr_pc_gen_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [15:0] instr = '0, pc_inc = '0, base_val = '0, vec_data = '0;
  logic        flag_n = 1'b0, flag_z = 1'b0, flag_p = 1'b0;
  logic [15:0] mar_addr, next_pc, link_data;
  logic        br_taken, link_we;

  int total = 0;
  int bad = 0;
  bit done = 0;
  int cycles = 0;

  addr_pc_gen u_dut (
    .instr(instr), .pc_inc(pc_inc), .base_val(base_val),
    .flag_n(flag_n), .flag_z(flag_z), .flag_p(flag_p), .vec_data(vec_data),
    .mar_addr(mar_addr), .next_pc(next_pc), .br_taken(br_taken),
    .link_we(link_we), .link_data(link_data)
  );

  function automatic int signed_of(int v, int w);
    return (v >= (1 << (w - 1))) ? v - (1 << w) : v;
  endfunction

  function automatic logic [15:0] wrap(int v);
    return 16'(v & 32'hFFFF);
  endfunction

  function automatic logic exp_taken(logic [15:0] w, logic n, logic z, logic p);
    if (w[15:12] != 4'h0) return 1'b0;
    return (w[11] && n) || (w[10] && z) || (w[9] && p);
  endfunction

  function automatic logic [15:0] exp_npc(logic [15:0] w, logic [15:0] pc, logic [15:0] b,
                                          logic [15:0] vd, logic n, logic z, logic p);
    case (w[15:12])
      4'h0: return exp_taken(w, n, z, p) ? wrap(int'(pc) + signed_of(int'(w[8:0]), 9)) : pc;
      4'h4: return w[11] ? wrap(int'(pc) + signed_of(int'(w[10:0]), 11)) : b;
      4'hC: return b;
      4'hF: return vd;
      default: return pc;
    endcase
  endfunction

  function automatic logic mar_defined(logic [15:0] w);
    case (w[15:12])
      4'h0, 4'h2, 4'h3, 4'hA, 4'hB, 4'hE, 4'h6, 4'h7, 4'hF: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [15:0] exp_mar(logic [15:0] w, logic [15:0] pc, logic [15:0] b);
    case (w[15:12])
      4'h6, 4'h7: return wrap(int'(b) + signed_of(int'(w[5:0]), 6));
      4'hF: return 16'(w[7:0]);
      default: return wrap(int'(pc) + signed_of(int'(w[8:0]), 9));
    endcase
  endfunction

  function automatic string req_of(logic [3:0] op);
    case (op)
      4'h0: return "R3";
      4'h2, 4'h3, 4'hA, 4'hB, 4'hE: return "R1";
      4'h6, 4'h7: return "R2";
      4'hC: return "R5";
      4'h4: return "R6";
      4'hF: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic chk(string req, string what, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s instr=%h actual=%h expected=%h", req, what, instr, act, exp);
    end
  endtask

  task automatic apply(logic [15:0] w, logic [15:0] pc, logic [15:0] b, logic [15:0] vd,
                       logic [2:0] nzp);
    logic [15:0] e_link;
    logic        e_lwe;
    string       rq;
    @(negedge clk);
    instr = w; pc_inc = pc; base_val = b; vec_data = vd;
    {flag_n, flag_z, flag_p} = nzp;
    @(posedge clk);
    #1;
    rq = req_of(w[15:12]);
    if (w[15:12] == 4'h0 && w[11:9] == 3'b000) rq = "R4";
    e_lwe  = (w[15:12] == 4'h4) || (w[15:12] == 4'hF);
    e_link = e_lwe ? pc : 16'h0000;
    chk(rq, "next_pc", next_pc, exp_npc(w, pc, b, vd, nzp[2], nzp[1], nzp[0]));
    chk((w[15:12] == 4'h0) ? rq : "R9", "br_taken", {15'd0, br_taken},
        {15'd0, exp_taken(w, nzp[2], nzp[1], nzp[0])});
    chk(e_lwe ? rq : "R9", "link_we", {15'd0, link_we}, {15'd0, e_lwe});
    chk("R9", "link_data", link_data, e_link);
    if (mar_defined(w))
      chk((w[15:12] == 4'h0) ? "R1" : rq, "mar_addr", mar_addr, exp_mar(w, pc, b));
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000 && !done) begin
        bad++;
        total++;
        $display("FAIL watchdog actual=%0d expected<150000", cycles);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'h1C3A_5EED));
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // idle word after reset: empty-mask branch, R4
    apply(16'h0000, 16'h3000, 16'h1234, 16'hBEEF, 3'b111);
    // R1 offset extremes with wrap
    apply(16'h2100, 16'h0010, 16'h0, 16'h0, 3'b010);   // -256
    apply(16'hE0FF, 16'hFFF0, 16'h0, 16'h0, 3'b001);   // +255 wraps
    apply(16'hA1FF, 16'h0000, 16'h0, 16'h0, 3'b100);   // -1 wraps
    // R2 base+offset extremes
    apply(16'h6020, 16'h4000, 16'h0005, 16'h0, 3'b001); // -32
    apply(16'h701F, 16'h4000, 16'hFFF0, 16'h0, 3'b001); // +31 wraps
    // R3 each mask bit against each single flag
    for (int m = 0; m < 3; m++)
      for (int f = 0; f < 3; f++)
        apply({4'h0, 3'(1 << m), 9'h1F0}, 16'h0100, 16'h0, 16'h0, 3'(1 << f));
    apply(16'h0E05, 16'h0100, 16'h0, 16'h0, 3'b000);   // full mask, no flags
    // R5 jump, R6 calls
    apply(16'hC1C0, 16'h2222, 16'h8001, 16'h0, 3'b010);
    apply(16'h4C00, 16'h0200, 16'h0, 16'h0, 3'b010);   // -1024
    apply(16'h4BFF, 16'hFE00, 16'h0, 16'h0, 3'b010);   // +1023 wraps
    apply(16'h4080, 16'h0200, 16'h7777, 16'h0, 3'b010); // register form
    // R7 trap
    apply(16'hF0FF, 16'h3005, 16'h0, 16'hA5C3, 3'b100);
    apply(16'hF025, 16'h3005, 16'h0, 16'h0400, 3'b001);
    // R8 non-control opcodes
    apply(16'h1FFF, 16'h5555, 16'hAAAA, 16'h1111, 3'b100);
    apply(16'hD000, 16'h5555, 16'hAAAA, 16'h1111, 3'b100);
    // random mix
    for (int i = 0; i < 3000; i++)
      apply(16'($urandom), 16'($urandom), 16'($urandom), 16'($urandom), 3'($urandom));
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule